// File: doc/BRIEF.md
# Multi-Granular Region Hit-Miss Predictor

This block guesses, from a physical address alone, whether a request to a large DRAM-based last-level cache will find its line there. Requests predicted to miss can go straight to off-chip memory, so the cache is not probed for them. No per-line record is kept. Instead, three small tables of two-bit saturating counters cover address regions of 4MB, 256KB and 4KB. The 4MB table is untagged and always answers. The two finer tables are tagged, and a tag match there takes over from the coarser answer.

A lookup presents an address with a valid strobe, and the answer appears one clock later. When the cache tags are later checked for a request, the true outcome is fed back on the update port. The counter that supplied the prediction is then trained. If the guess was wrong, an entry is allocated one level finer. A predicted miss that was really a hit is flagged on a dedicated output, so the memory system can recover.

Top module: `region_hit_predictor`

## Requirements
- R1: A lookup with `lk_valid` high at a rising edge yields `pred_valid` high in the following cycle and low otherwise; only the address is used.
- R2: Every entry holds a two-bit counter; it predicts hit when the counter is 2 or 3. After reset, base counters are 1 (weak miss) and all tagged entries are invalid, so every address predicts miss.
- R3: The base table is untagged and indexed by address bits [25:22]; all addresses in one 4MB region with no tagged match share its prediction.
- R4: The middle table is indexed by bits [20:18] with partial tag bits [26:21]; the fine table by bits [14:12] with tag bits [20:15]; an entry matches only when valid and its tag equals the address tag.
- R5: When several levels match, the finest matching table supplies the prediction.
- R6: `miss_err` pulses high the cycle after an update whose prediction was miss and whose actual outcome was hit; a predicted hit that misses, or a correct prediction, leaves it low.
- R7: On a wrong prediction from the base table an entry is written in the middle table; from the middle table, in the fine table. The new entry gets counter 2 for an actual hit and 1 for an actual miss. A wrong fine-table prediction allocates nothing.
- R8: Only the providing entry's counter is trained: up on hit, down on miss, saturating at 3 and 0.
- R9: `pred_hit` is low whenever `pred_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Lookup physical address |
| pred_valid | output | 1 | Prediction available |
| pred_hit | output | 1 | Predicted hit (1) or miss (0) |
| upd_valid | input | 1 | Outcome report strobe |
| upd_addr | input | ADDR_W | Address whose outcome is reported |
| upd_hit | input | 1 | Actual outcome, 1 for hit |
| miss_err | output | 1 | Predicted miss turned out to be a hit |

## Verification
The hardest situation to reach is one where the finest table overrides both coarser levels while they disagree with it. A 4KB entry exists only after the middle table has itself been allocated and has then guessed wrong. The stimulus therefore trains one region in steps. A base-level false miss creates a middle entry, and a miss against that entry creates a fine entry. Further hits and misses then walk that fine counter through both saturation points, while neighbouring pages and a tag-aliasing address confirm that the other levels keep their own state.

// File: rtl/region_hit_predictor.sv
module region_hit_predictor #(
  parameter int ADDR_W     = 32,
  parameter int BASE_SHIFT = 22,
  parameter int BASE_IDX_W = 4,
  parameter int MID_SHIFT  = 18,
  parameter int MID_IDX_W  = 3,
  parameter int FINE_SHIFT = 12,
  parameter int FINE_IDX_W = 3,
  parameter int TAG_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              pred_valid,
  output logic              pred_hit,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_hit,
  output logic              miss_err
);
  localparam int BASE_N = 1 << BASE_IDX_W;
  localparam int MID_N  = 1 << MID_IDX_W;
  localparam int FINE_N = 1 << FINE_IDX_W;
  localparam logic [1:0] LVL_BASE = 2'd0, LVL_MID = 2'd1, LVL_FINE = 2'd2;

  logic [1:0]       base_ctr [BASE_N];
  logic [1:0]       mid_ctr  [MID_N];
  logic [TAG_W-1:0] mid_tag  [MID_N];
  logic             mid_v    [MID_N];
  logic [1:0]       fine_ctr [FINE_N];
  logic [TAG_W-1:0] fine_tag [FINE_N];
  logic             fine_v   [FINE_N];

  function automatic logic [3:0] probe(input logic [ADDR_W-1:0] a);
    logic [BASE_IDX_W-1:0] bi;
    logic [MID_IDX_W-1:0]  mi;
    logic [FINE_IDX_W-1:0] fi;
    bi = a[BASE_SHIFT +: BASE_IDX_W];
    mi = a[MID_SHIFT +: MID_IDX_W];
    fi = a[FINE_SHIFT +: FINE_IDX_W];
    if (fine_v[fi] && fine_tag[fi] == a[FINE_SHIFT+FINE_IDX_W +: TAG_W])
      return {LVL_FINE, fine_ctr[fi]};
    else if (mid_v[mi] && mid_tag[mi] == a[MID_SHIFT+MID_IDX_W +: TAG_W])
      return {LVL_MID, mid_ctr[mi]};
    else
      return {LVL_BASE, base_ctr[bi]};
  endfunction

  function automatic logic [1:0] train(input logic [1:0] c, input logic hit);
    if (hit) return (c == 2'd3) ? c : c + 2'd1;
    else     return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  logic [3:0] lk_probe, up_probe;
  assign lk_probe = probe(lk_addr);
  assign up_probe = probe(upd_addr);

  logic [1:0] up_lvl, up_ctr, up_new, alloc_ctr;
  logic       up_wrong;
  assign up_lvl    = up_probe[3:2];
  assign up_ctr    = up_probe[1:0];
  assign up_wrong  = up_ctr[1] != upd_hit;
  assign up_new    = train(up_ctr, upd_hit);
  assign alloc_ctr = upd_hit ? 2'd2 : 2'd1;

  logic [BASE_IDX_W-1:0] u_bi;
  logic [MID_IDX_W-1:0]  u_mi;
  logic [FINE_IDX_W-1:0] u_fi;
  assign u_bi = upd_addr[BASE_SHIFT +: BASE_IDX_W];
  assign u_mi = upd_addr[MID_SHIFT +: MID_IDX_W];
  assign u_fi = upd_addr[FINE_SHIFT +: FINE_IDX_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{lk_addr, upd_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_hit   <= 1'b0;
      miss_err   <= 1'b0;
      for (int i = 0; i < BASE_N; i++) base_ctr[i] <= 2'd1;
      for (int i = 0; i < MID_N; i++) begin
        mid_ctr[i] <= 2'd1; mid_tag[i] <= '0; mid_v[i] <= 1'b0;
      end
      for (int i = 0; i < FINE_N; i++) begin
        fine_ctr[i] <= 2'd1; fine_tag[i] <= '0; fine_v[i] <= 1'b0;
      end
    end else begin
      pred_valid <= lk_valid;
      pred_hit   <= lk_valid & lk_probe[1];
      miss_err   <= upd_valid & upd_hit & ~up_ctr[1];
      if (upd_valid) begin
        case (up_lvl)
          LVL_BASE: begin
            base_ctr[u_bi] <= up_new;
            if (up_wrong) begin
              mid_v[u_mi]   <= 1'b1;
              mid_tag[u_mi] <= upd_addr[MID_SHIFT+MID_IDX_W +: TAG_W];
              mid_ctr[u_mi] <= alloc_ctr;
            end
          end
          LVL_MID: begin
            mid_ctr[u_mi] <= up_new;
            if (up_wrong) begin
              fine_v[u_fi]   <= 1'b1;
              fine_tag[u_fi] <= upd_addr[FINE_SHIFT+FINE_IDX_W +: TAG_W];
              fine_ctr[u_fi] <= alloc_ctr;
            end
          end
          default: fine_ctr[u_fi] <= up_new;
        endcase
      end
    end
  end
endmodule

module region_hit_predictor_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic pred_valid,
  input logic pred_hit,
  input logic upd_valid,
  input logic upd_hit,
  input logic miss_err
);
  // R1
  lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);
  // R1
  no_spurious_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);
  // R6
  err_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_hit) |=> !miss_err);
  // R9
  idle_pred_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> !pred_hit);
endmodule

bind region_hit_predictor region_hit_predictor_chk i_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .pred_valid(pred_valid),
  .pred_hit(pred_hit), .upd_valid(upd_valid), .upd_hit(upd_hit),
  .miss_err(miss_err)
);

// File: tb/test_region_hit_predictor.sv
module test_region_hit_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  localparam logic [AW-1:0] ADDR_A = 32'h0004_2000;
  localparam logic [AW-1:0] ADDR_B = 32'h000C_0000;
  localparam logic [AW-1:0] ADDR_C = 32'h0004_3000;
  localparam logic [AW-1:0] ADDR_E = 32'h0040_0000;
  localparam logic [AW-1:0] ADDR_F = 32'h0044_0000;
  localparam logic [AW-1:0] ADDR_G = 32'h0084_A000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, upd_valid = 1'b0, upd_hit = 1'b0;
  logic [AW-1:0] lk_addr = '0, upd_addr = '0;
  logic pred_valid, pred_hit, miss_err;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_hit_predictor i_region_hit_predictor (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_hit(upd_hit), .miss_err(miss_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a, input logic exp_hit, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " pred_valid"}, pred_valid, 1'b1);
    check({req, " pred_hit"}, pred_hit, exp_hit);
  endtask

  task automatic update(input logic [AW-1:0] a, input logic hit, input logic exp_err, input string req);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_hit = hit;
    @(negedge clk);
    upd_valid = 1'b0;
    check({req, " miss_err"}, miss_err, exp_err);
  endtask

  task automatic t_reset();
    check("R1 reset pred_valid", pred_valid, 1'b0);
    check("R6 reset miss_err", miss_err, 1'b0);
    lookup(ADDR_A, 1'b0, "R2 reset weak miss");
    lookup(ADDR_G, 1'b0, "R2 reset weak miss other region");
    @(negedge clk);
    check("R1 idle pred_valid", pred_valid, 1'b0);
    check("R9 idle pred_hit", pred_hit, 1'b0);
  endtask

  task automatic t_first_hit();
    update(ADDR_A, 1'b1, 1'b1, "R6 false miss flagged");
    lookup(ADDR_A, 1'b1, "R7 mid allocated weak hit");
    lookup(ADDR_B, 1'b1, "R3 base shared in 4MB region");
  endtask

  task automatic t_override();
    update(ADDR_A, 1'b0, 1'b0, "R6 false hit harmless");
    lookup(ADDR_A, 1'b0, "R5 fine overrides base");
    lookup(ADDR_C, 1'b0, "R8 mid trained down");
    lookup(ADDR_B, 1'b1, "R8 base untouched when not provider");
  endtask

  task automatic t_saturate_hi();
    update(ADDR_A, 1'b1, 1'b1, "R6 fine weak miss flagged");
    update(ADDR_A, 1'b1, 1'b0, "R8 fine now hit");
    update(ADDR_A, 1'b1, 1'b0, "R8 fine at 3");
    update(ADDR_A, 1'b0, 1'b0, "R6 hit predicted then miss");
    lookup(ADDR_A, 1'b1, "R8 saturate at 3");
    lookup(ADDR_C, 1'b0, "R7 fine error allocates nothing");
  endtask

  task automatic t_saturate_lo();
    update(ADDR_E, 1'b0, 1'b0, "R6 correct miss");
    update(ADDR_E, 1'b0, 1'b0, "R6 correct miss at 0");
    lookup(ADDR_E, 1'b0, "R8 saturate at 0");
    update(ADDR_E, 1'b1, 1'b1, "R6 false miss from base");
    lookup(ADDR_E, 1'b1, "R7 mid allocated for E");
    lookup(ADDR_F, 1'b0, "R8 base back to 1");
  endtask

  task automatic t_tag_miss();
    lookup(ADDR_G, 1'b0, "R4 tag mismatch uses base");
    lookup(ADDR_A, 1'b1, "R4 matching tag still used");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_hit();
    t_override();
    t_saturate_hi();
    t_saturate_lo();
    t_tag_miss();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule